// File: doc/BRIEF.md
# Serial Byte-Memory Slave on a Two-Wire Bus

This block is the slave side of a two-wire (I2C) serial memory holding 2^ADDR_W bytes (256 by default). It oversamples the clock and data lines with the system clock and recognises bus START and STOP conditions. It frames bits into bytes, pulls the data line low to acknowledge, and on reads shifts out stored bytes from the current word address.

A write transaction carries a select byte, a word address and one or more data bytes. The data bytes are gathered in a small staging buffer and are not placed in the array when they arrive. The STOP that closes the write starts an internal programming period of PROG_CYCLES system clocks. During that period `busy_o` is high and the bus is not observed at all. The staged bytes reach the array when the period ends. A repeated START after the word address turns a write into a random-address read.

The data line is open-drain. The block only ever asks for the line to be pulled low, through `sda_oe_o`, and the pad or the board combines that request with the other bus drivers.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: Nothing on the bus is answered until a START (data falling while the clock is high) has been seen. Clock pulses before any START get no acknowledge, and `sda_oe_o` stays 0.
- R2: The first byte after a START is the select byte. It is accepted, and acknowledged by `sda_oe_o`=1 during the 9th clock, only when bits 7..4 are 1010 and bits 3..1 are 000. Bit 0 = 1 requests a read and bit 0 = 0 requests a write. Any other select byte is not acknowledged, and the block then ignores the bus until the next START.
- R3: Bytes travel most significant bit first. The block acknowledges the word address byte and every write data byte in the 9th clock. It changes `sda_oe_o` only while the synchronised clock line is low.
- R4: The word address advances by one after every data byte transferred in either direction, wrapping from 255 to 0.
- R5: A read returns the byte stored at the current word address. A master acknowledge (data low in the 9th clock) makes the block send the next byte. A master no-acknowledge (data high) makes it release the data line and stop sending.
- R6: A STOP that closes a write holding at least one data byte raises `busy_o` on the next clock for exactly PROG_CYCLES clocks. The staged bytes are visible in the array once `busy_o` falls.
- R7: While `busy_o` is high, START, STOP and clock activity are all ignored: there is no acknowledge and `sda_oe_o` stays 0.
- R8: A STOP that closes a read returns the block to standby and does not raise `busy_o`.
- R9: A START that arrives before the closing STOP discards the staged write bytes, which are never programmed. The word address is kept, so a repeated START followed by a read select performs a random-address read.
- R10: The staging buffer holds BUF_DEPTH bytes. Further data bytes in the same write are still acknowledged, but they are discarded.
- R11: After reset, `busy_o` is 0, `sda_oe_o` is 0 and every array location reads 0xFF.
- R12: A read select with no preceding address phase starts at the word address left by the previous transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 requests the data line to be pulled low |
| busy_o | output | 1 | High during the internal programming period |

## Verification
Writes are run at an ordinary address, across the 255-to-0 boundary, and with more bytes than the buffer holds. Each is read back after the programming period, so auto-increment, wrap and overflow dropping show up as distinct value patterns. Select bytes that differ from the accepted code in the high nibble or in the low fixed bits are sent, as are clock pulses with no START at all, and a START issued while programming is under way. Each of these must yield a no-acknowledge, which separates condition detection from select matching. A write that is cut short by a repeated START is then re-read at its target address, which shows whether data is committed on STOP alone.

// File: rtl/eeprom_i2c_pkg.sv
package eeprom_i2c_pkg;
   localparam int BYTE_W = 8;
   // Upper seven bits of an accepted select byte (the low bit is the direction)
   localparam logic [6:0] SEL_CODE = 7'b1010_000;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_SEL,
      PH_WADDR,
      PH_WDATA,
      PH_RDATA
   } phase_e;
endpackage

// File: rtl/eeprom_i2c_cond.sv
module eeprom_i2c_cond #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_evt,
   output logic stop_evt
);
   logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
   logic scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sh <= '1;
         sda_sh <= '1;
         scl_d  <= 1'b1;
         sda_d  <= 1'b1;
      end else begin
         scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
         sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
         scl_d  <= scl_lvl;
         sda_d  <= sda_lvl;
      end
   end

   assign scl_lvl   = scl_sh[SYNC_STAGES-1];
   assign sda_lvl   = sda_sh[SYNC_STAGES-1];
   assign scl_rise  = scl_lvl & ~scl_d;
   assign scl_fall  = ~scl_lvl & scl_d;
   // Data edges while the clock stays high are bus conditions
   assign start_evt = scl_lvl & scl_d & sda_d & ~sda_lvl;
   assign stop_evt  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/eeprom_prog_timer.sv
module eeprom_prog_timer #(
   parameter int PROG_CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o,
   output logic done_o
);
   localparam int CNT_W = $clog2(PROG_CYCLES + 1);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         cnt_q  <= '0;
      end else if (busy_o) begin
         if (cnt_q == '0) busy_o <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end else if (start_i) begin
         busy_o <= 1'b1;
         cnt_q  <= CNT_W'(PROG_CYCLES - 1);
      end
   end

   assign done_o = busy_o & (cnt_q == '0);
endmodule

// File: rtl/eeprom_mem_core.sv
module eeprom_mem_core
   import eeprom_i2c_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int BUF_DEPTH = 8,
   parameter logic [BYTE_W-1:0] INIT_VAL = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              push_i,
   input  logic [ADDR_W-1:0] push_addr,
   input  logic [BYTE_W-1:0] push_data,
   input  logic              commit_i,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [BYTE_W-1:0] rd_data,
   output logic              pending_o
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int CNT_W = $clog2(BUF_DEPTH + 1);

   logic [BYTE_W-1:0] mem_q [DEPTH];
   logic [BYTE_W-1:0] buf_q [BUF_DEPTH];
   logic [ADDR_W-1:0] base_q;
   logic [CNT_W-1:0]  cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         base_q <= '0;
      end else if (clear_i || commit_i) begin
         cnt_q <= '0;
      end else if (push_i) begin
         if (cnt_q == '0) base_q <= push_addr;
         if (cnt_q < CNT_W'(BUF_DEPTH)) cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push_i && !clear_i && !commit_i && cnt_q < CNT_W'(BUF_DEPTH))
         buf_q[cnt_q[$clog2(BUF_DEPTH > 1 ? BUF_DEPTH : 2)-1:0]] <= push_data;
   end

   // One write port per row: the row takes the staged byte whose address lands on it
   for (genvar r = 0; r < DEPTH; r++) begin : g_row
      logic              hit;
      logic [BYTE_W-1:0] wval;
      always_comb begin
         hit  = 1'b0;
         wval = buf_q[0];
         for (int i = 0; i < BUF_DEPTH; i++) begin
            if (CNT_W'(i) < cnt_q && (base_q + ADDR_W'(i)) == ADDR_W'(r)) begin
               hit  = 1'b1;
               wval = buf_q[i];
            end
         end
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)               mem_q[r] <= INIT_VAL;
         else if (commit_i && hit) mem_q[r] <= wval;
      end
   end

   assign rd_data   = mem_q[rd_addr];
   assign pending_o = (cnt_q != '0);
endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
   import eeprom_i2c_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int BUF_DEPTH   = 8,
   parameter int PROG_CYCLES = 1000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_oe_o,
   output logic busy_o
);
   initial begin : p_param_chk
      assert (ADDR_W >= 1 && ADDR_W <= BYTE_W) else $error("ADDR_W out of range");
      assert (BUF_DEPTH >= 1) else $error("BUF_DEPTH must be at least 1");
      assert (PROG_CYCLES >= 2) else $error("PROG_CYCLES must be at least 2");
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
   end

   logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
   logic prog_start, prog_done, pending;
   logic [BYTE_W-1:0] rd_data;

   phase_e            phase_q;
   logic [3:0]        cnt_q;
   logic [BYTE_W-1:0] shreg_q, tx_q;
   logic [ADDR_W-1:0] waddr_q;
   logic              rw_q, nack_q, drive_q;
   logic              st_ok, sp_ok, push;
   logic [2:0]        tx_idx;

   eeprom_i2c_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt)
   );

   eeprom_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .start_i(prog_start),
      .busy_o(busy_o), .done_o(prog_done)
   );

   eeprom_mem_core #(.ADDR_W(ADDR_W), .BUF_DEPTH(BUF_DEPTH)) u_mem (
      .clk(clk), .rst_n(rst_n), .clear_i(st_ok), .push_i(push),
      .push_addr(waddr_q), .push_data(shreg_q), .commit_i(prog_done),
      .rd_addr(waddr_q), .rd_data(rd_data), .pending_o(pending)
   );

   // The bus is invisible while programming
   assign st_ok      = start_evt & ~busy_o;
   assign sp_ok      = stop_evt & ~busy_o;
   assign prog_start = sp_ok & pending;
   assign push       = ~st_ok & ~sp_ok & scl_fall & (cnt_q == 4'd8) & (phase_q == PH_WDATA);
   assign tx_idx     = 3'(4'd7 - cnt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         shreg_q <= '0;
         tx_q    <= '0;
         waddr_q <= '0;
         rw_q    <= 1'b0;
         nack_q  <= 1'b0;
         drive_q <= 1'b0;
      end else if (st_ok) begin
         phase_q <= PH_SEL;
         cnt_q   <= '0;
         drive_q <= 1'b0;
      end else if (sp_ok) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         drive_q <= 1'b0;
      end else if (phase_q != PH_IDLE) begin
         if (scl_rise) begin
            if (cnt_q < 4'd8) begin
               shreg_q <= {shreg_q[BYTE_W-2:0], sda_lvl};
               cnt_q   <= cnt_q + 1'b1;
            end else if (cnt_q == 4'd8) begin
               cnt_q  <= 4'd9;
               nack_q <= sda_lvl;
            end
         end else if (scl_fall) begin
            if (cnt_q == 4'd8) begin
               unique case (phase_q)
                  PH_SEL: begin
                     if (shreg_q[7:1] == SEL_CODE) begin
                        drive_q <= 1'b1;
                        rw_q    <= shreg_q[0];
                     end else begin
                        phase_q <= PH_IDLE;
                        cnt_q   <= '0;
                        drive_q <= 1'b0;
                     end
                  end
                  PH_WADDR: begin
                     waddr_q <= shreg_q[ADDR_W-1:0];
                     drive_q <= 1'b1;
                  end
                  PH_WDATA: begin
                     waddr_q <= waddr_q + 1'b1;
                     drive_q <= 1'b1;
                  end
                  default: begin
                     waddr_q <= waddr_q + 1'b1;
                     drive_q <= 1'b0;
                  end
               endcase
            end else if (cnt_q == 4'd9) begin
               cnt_q <= '0;
               unique case (phase_q)
                  PH_SEL: begin
                     if (rw_q) begin
                        phase_q <= PH_RDATA;
                        tx_q    <= rd_data;
                        drive_q <= ~rd_data[7];
                     end else begin
                        phase_q <= PH_WADDR;
                        drive_q <= 1'b0;
                     end
                  end
                  PH_WADDR: begin
                     phase_q <= PH_WDATA;
                     drive_q <= 1'b0;
                  end
                  PH_WDATA: drive_q <= 1'b0;
                  default: begin
                     if (nack_q) begin
                        phase_q <= PH_IDLE;
                        drive_q <= 1'b0;
                     end else begin
                        tx_q    <= rd_data;
                        drive_q <= ~rd_data[7];
                     end
                  end
               endcase
            end else if (phase_q == PH_RDATA && cnt_q != 4'd0) begin
               drive_q <= ~tx_q[tx_idx];
            end
         end
      end
   end

   assign sda_oe_o = drive_q;
endmodule

// File: rtl/eeprom_i2c_slave_chk.sv
module eeprom_i2c_slave_chk #(
   parameter int PROG_CYCLES = 1000
) (
   input logic clk,
   input logic rst_n,
   input logic sda_oe,
   input logic busy,
   input logic scl_lvl,
   input logic stop_evt
);
   localparam int RUN_W = $clog2(PROG_CYCLES + 2);
   logic [RUN_W-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           run_q <= '0;
      else if (!busy)                       run_q <= '0;
      else if (run_q != RUN_W'(PROG_CYCLES + 1)) run_q <= run_q + 1'b1;
   end

   // R7: no pull on the data line while programming
   a_r7_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !sda_oe);

   // R3: the pull request only starts while the clock line is low
   a_r3_drive_on_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_lvl);

   // R6: the busy run never exceeds the programmed length
   a_r6_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (run_q <= RUN_W'(PROG_CYCLES)));

   // R6: busy only starts right after a STOP
   a_r6_busy_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(stop_evt));
endmodule

bind eeprom_i2c_slave eeprom_i2c_slave_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
   .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe_o), .busy(busy_o),
   .scl_lvl(scl_lvl), .stop_evt(stop_evt)
);

// File: tb/eeprom_i2c_slave_tb_top.sv
module eeprom_i2c_slave_tb_top;
   localparam time CLK_PERIOD = 10ns;
   localparam int  PROG       = 600;
   localparam int  BUFD       = 8;
   localparam int  Q          = 8;
   localparam int  WATCHDOG   = 150000;

   typedef struct {
      string      req;
      logic [7:0] val;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic m_low = 1'b0;
   logic sda_oe, busy;
   logic sda_line;

   item_t      exp_q[$];
   logic [7:0] obs_v;
   event       obs_ev;
   int nchk = 0, nfail = 0;
   int run_len = 0, last_len = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;
   assign sda_line = ~(m_low | sda_oe);

   eeprom_i2c_slave #(.BUF_DEPTH(BUFD), .PROG_CYCLES(PROG)) dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe_o(sda_oe), .busy_o(busy)
   );

   // Monitor: pops the expected item and compares it with the observed one
   always begin
      @(obs_ev);
      nchk++;
      if (exp_q.size() == 0) begin
         nfail++;
         $display("FAIL unexpected item: actual %02h expected none", obs_v);
      end else begin
         item_t it;
         it = exp_q.pop_front();
         if (it.val !== obs_v) begin
            nfail++;
            $display("FAIL %s: actual %02h expected %02h", it.req, obs_v, it.val);
         end
      end
   end

   // Busy run-length recorder
   always @(negedge clk) begin
      if (busy) run_len++;
      else begin
         if (run_len != 0) last_len = run_len;
         run_len = 0;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      m_low = 1'b0; wq(Q);
      scl_m = 1'b1; wq(Q);
      m_low = 1'b1; wq(Q);
      scl_m = 1'b0; wq(Q);
   endtask

   task automatic bus_stop();
      m_low = 1'b1; wq(Q);
      scl_m = 1'b1; wq(Q);
      m_low = 1'b0; wq(Q);
   endtask

   task automatic put_bit(input logic b);
      m_low = ~b; wq(Q);
      scl_m = 1'b1; wq(2*Q);
      scl_m = 1'b0; wq(Q);
   endtask

   task automatic get_bit(output logic b);
      m_low = 1'b0; wq(Q);
      scl_m = 1'b1; wq(Q);
      b = sda_line; wq(Q);
      scl_m = 1'b0; wq(Q);
   endtask

   // Driver: send a byte and queue the expected acknowledge (0 = ACK, 1 = none)
   task automatic wr_byte(input logic [7:0] b, input logic exp_nack, input string req);
      logic a;
      exp_q.push_back('{req, {7'd0, exp_nack}});
      for (int i = 7; i >= 0; i--) put_bit(b[i]);
      get_bit(a);
      obs_v = {7'd0, a};
      ->obs_ev;
   endtask

   // Driver: receive a byte, queue its expected value, answer with ack or nack
   task automatic rd_byte(input logic [7:0] exp_v, input logic nack, input string req);
      logic [7:0] v;
      logic b;
      exp_q.push_back('{req, exp_v});
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         v[i] = b;
      end
      obs_v = v;
      ->obs_ev;
      put_bit(nack);
   endtask

   task automatic wait_prog();
      wq(2);
      while (busy) @(negedge clk);
      wq(2);
   endtask

   task automatic set_addr(input logic [7:0] a, input string req);
      bus_start();
      wr_byte(8'hA0, 1'b0, req);
      wr_byte(a, 1'b0, req);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      wq(5);
      rst_n = 1'b1;
      wq(3);
      check("R11 sda released after reset", sda_oe, 0);
      check("R11 busy low after reset", busy, 0);

      // R1: clocks without any START are ignored
      scl_m = 1'b0; wq(Q);
      wr_byte(8'hA0, 1'b1, "R1 no ack before START");
      check("R1 sda released", sda_oe, 0);
      bus_stop();

      // R11: unwritten locations read as erased
      set_addr(8'h40, "R11 setup");
      bus_start();
      wr_byte(8'hA1, 1'b0, "R2 read select ack");
      rd_byte(8'hFF, 1'b0, "R11 erased 0x40");
      rd_byte(8'hFF, 1'b1, "R11 erased 0x41");
      bus_stop();
      wq(4);
      check("R8 no busy after read STOP", busy, 0);

      // R3/R6: write four bytes, commit on STOP
      set_addr(8'h10, "R3 address ack");
      wr_byte(8'h5A, 1'b0, "R3 data ack");
      wr_byte(8'hC3, 1'b0, "R3 data ack");
      wr_byte(8'h01, 1'b0, "R3 data ack");
      wr_byte(8'h77, 1'b0, "R3 data ack");
      check("R6 busy not yet before STOP", busy, 0);
      bus_stop();
      check("R6 busy after write STOP", busy, 1);
      wait_prog();
      check("R6 busy length", last_len, PROG);

      // R5: random read back, stop after three bytes
      set_addr(8'h10, "R5 setup");
      bus_start();
      wr_byte(8'hA1, 1'b0, "R5 read select");
      rd_byte(8'h5A, 1'b0, "R5 byte 0x10");
      rd_byte(8'hC3, 1'b0, "R4 byte 0x11");
      rd_byte(8'h01, 1'b1, "R4 byte 0x12");
      check("R5 sda released after nack", sda_oe, 0);
      bus_stop();

      // R12: current address read resumes at 0x13
      bus_start();
      wr_byte(8'hA1, 1'b0, "R12 read select");
      rd_byte(8'h77, 1'b1, "R12 current address");
      bus_stop();

      // R2: mismatching select bytes
      bus_start();
      wr_byte(8'hB0, 1'b1, "R2 wrong high nibble");
      wr_byte(8'h00, 1'b1, "R2 stays idle");
      bus_stop();
      bus_start();
      wr_byte(8'hA2, 1'b1, "R2 wrong low bits");
      check("R2 sda released", sda_oe, 0);
      bus_stop();

      // R4: wrap from 255 to 0
      set_addr(8'hFE, "R4 setup");
      wr_byte(8'h11, 1'b0, "R4 data");
      wr_byte(8'h22, 1'b0, "R4 data");
      wr_byte(8'h33, 1'b0, "R4 data");
      bus_stop();
      wait_prog();
      set_addr(8'hFE, "R4 setup");
      bus_start();
      wr_byte(8'hA1, 1'b0, "R4 read select");
      rd_byte(8'h11, 1'b0, "R4 byte 0xFE");
      rd_byte(8'h22, 1'b0, "R4 byte 0xFF");
      rd_byte(8'h33, 1'b1, "R4 byte 0x00 after wrap");
      bus_stop();

      // R10: more data bytes than the buffer holds
      set_addr(8'h20, "R10 setup");
      for (int i = 0; i < BUFD + 2; i++) wr_byte(8'h80 + 8'(i), 1'b0, "R10 ack beyond buffer");
      bus_stop();
      wait_prog();
      set_addr(8'h27, "R10 setup");
      bus_start();
      wr_byte(8'hA1, 1'b0, "R10 read select");
      rd_byte(8'h87, 1'b0, "R10 last kept byte");
      rd_byte(8'hFF, 1'b1, "R10 dropped byte");
      bus_stop();

      // R7: bus ignored while programming
      set_addr(8'h30, "R7 setup");
      wr_byte(8'h44, 1'b0, "R7 data");
      bus_stop();
      bus_start();
      wr_byte(8'hA0, 1'b1, "R7 no ack while busy");
      check("R7 still busy", busy, 1);
      bus_stop();
      wait_prog();
      set_addr(8'h30, "R7 setup");
      bus_start();
      wr_byte(8'hA1, 1'b0, "R7 read select");
      rd_byte(8'h44, 1'b1, "R7 data committed");
      bus_stop();

      // R9: repeated START discards staged bytes
      set_addr(8'h50, "R9 setup");
      wr_byte(8'h99, 1'b0, "R9 data");
      bus_start();
      wr_byte(8'hA1, 1'b0, "R9 read select");
      rd_byte(8'hFF, 1'b1, "R9 next address unwritten");
      bus_stop();
      wq(4);
      check("R9 no programming", busy, 0);
      set_addr(8'h50, "R9 setup");
      bus_start();
      wr_byte(8'hA1, 1'b0, "R9 read select");
      rd_byte(8'hFF, 1'b1, "R9 discarded byte");
      bus_stop();

      wq(10);
      check("scoreboard drained", exp_q.size(), 0);
      finish_run();
   end
endmodule